// File: doc/BRIEF.md
# Periodic Tick Interrupt Pending Tracker

This block sits between a free-running periodic tick source and an interrupt line that uses an acknowledge handshake. Ticks that arrive while an earlier interrupt is still unacknowledged are not lost. They are held in a saturating backlog counter and handed out again, one delivery per acknowledge, so a stalled consumer still sees every tick once it catches up.

A delivery is allowed only when the backlog is nonzero and the previous delivery has been acknowledged. Each delivery appears as a single-cycle pulse on the interrupt output. In the same cycle, a strobe goes to the local interrupt input of every core that the `CORE_PRESENT` parameter marks as present. A restart input, used when the tick source is reprogrammed, clears the backlog and re-arms delivery, exactly as reset does.

Top module: `tick_pend_tracker`

## Requirements
- R1: After reset, `pending_o`, `irq_o` and every bit of `core_strobe_o` are 0, and the acknowledge-ready flag is set, so the first tick that follows reset gets delivered.
- R2: A cycle with `tick_i`=1, `ack_i`=0 and `restart_i`=0 raises the backlog count by one. `pending_o` reads 1 from the following cycle on.
- R3: A cycle with `ack_i`=1, `tick_i`=0 and `restart_i`=0 lowers the backlog count by one. When the count is already 0 it stays at 0.
- R4: A delivery is decided in a cycle where the backlog is nonzero and the ready flag is set. `irq_o` is 1 for exactly the next cycle, and the decision clears the ready flag. Without an acknowledge, no further delivery follows.
- R5: An acknowledge sets the ready flag. If the backlog is still nonzero after that acknowledge, the next delivery is decided in the cycle that follows it. An acknowledge in the same cycle as a delivery decision leaves the flag set.
- R6: `core_strobe_o[i]` equals `irq_o` for every core i whose bit in `CORE_PRESENT` is 1, and is 0 for every core whose bit is 0.
- R7: `restart_i`=1 clears the backlog to 0, sets the ready flag, and blocks any delivery decision in that cycle. This holds whatever `tick_i` and `ack_i` are.
- R8: The backlog count saturates at 2^`CNT_W`-1. With the default `CNT_W`=4, 20 ticks followed by acknowledges leave `pending_o` at 1 after the 14th acknowledge and at 0 after the 15th.
- R9: A cycle with `tick_i`=1, `ack_i`=1 and `restart_i`=0 leaves the backlog count unchanged, including when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle tick from the periodic timer |
| ack_i | input | 1 | Acknowledge from the interrupt consumer |
| restart_i | input | 1 | Timer reprogrammed: clear backlog and re-arm |
| irq_o | output | 1 | One-cycle interrupt pulse to the interrupt controller |
| core_strobe_o | output | NUM_CORES | One-cycle strobes to the local interrupt input of each present core |
| pending_o | output | 1 | Backlog count is nonzero |

## Verification
Directed sequences cover four situations. A single tick followed by a late acknowledge separates gated delivery from free-running delivery. A 20-tick burst drained by acknowledges separates saturation from wraparound. Back-to-back tick-and-acknowledge cycles, both with an empty and with a loaded backlog, separate the hold rule from sequential increment then decrement. A restart issued over a loaded backlog shows whether the backlog is cleared and the ready flag re-armed. Long seeded random runs then mix these inputs at uneven rates, and a bench reference model checks every cycle, which exposes any wrong priority between restart, acknowledge and delivery.

// File: rtl/tick_pend_pkg.sv
package tick_pend_pkg;
  typedef enum logic [1:0] {
    CNT_HOLD = 2'd0,
    CNT_INC  = 2'd1,
    CNT_DEC  = 2'd2,
    CNT_CLR  = 2'd3
  } cnt_op_e;
endpackage

// File: rtl/tpt_pend_cnt.sv
module tpt_pend_cnt
  import tick_pend_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cnt_op_e          op_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             nz_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      unique case (op_i)
        CNT_CLR: cnt_q <= '0;
        CNT_INC: if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
        CNT_DEC: if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign cnt_o = cnt_q;
  assign nz_o  = (cnt_q != '0);
endmodule

// File: rtl/tpt_ack_gate.sv
module tpt_ack_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic ack_i,
  input  logic pend_nz_i,
  output logic deliver_o
);
  logic ready_q;

  assign deliver_o = pend_nz_i & ready_q & ~restart_i;

  // ack wins over a same-cycle delivery so the flag stays armed
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              ready_q <= 1'b1;
    else if (restart_i|ack_i) ready_q <= 1'b1;
    else if (deliver_o)       ready_q <= 1'b0;
  end
endmodule

// File: rtl/tpt_fanout.sv
module tpt_fanout #(
  parameter int                 NUM_CORES    = 4,
  parameter logic [NUM_CORES-1:0] CORE_PRESENT = '1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 deliver_i,
  output logic                 irq_o,
  output logic [NUM_CORES-1:0] strobe_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= deliver_i;
  end

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
    if (CORE_PRESENT[g]) begin : g_on
      logic stb_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stb_q <= 1'b0;
        else         stb_q <= deliver_i;
      end
      assign strobe_o[g] = stb_q;
    end else begin : g_off
      assign strobe_o[g] = 1'b0;
    end
  end
endmodule

// File: rtl/tick_pend_tracker.sv
module tick_pend_tracker
  import tick_pend_pkg::*;
#(
  parameter int                   CNT_W        = 4,
  parameter int                   NUM_CORES    = 4,
  parameter logic [NUM_CORES-1:0] CORE_PRESENT = 4'b1011
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic                 ack_i,
  input  logic                 restart_i,
  output logic                 irq_o,
  output logic [NUM_CORES-1:0] core_strobe_o,
  output logic                 pending_o
);
  cnt_op_e          op;
  logic [CNT_W-1:0] pend_cnt;
  logic             pend_nz;
  logic             deliver;

  always_comb begin
    if (restart_i)            op = CNT_CLR;
    else if (tick_i & ~ack_i) op = CNT_INC;
    else if (ack_i & ~tick_i) op = CNT_DEC;
    else                      op = CNT_HOLD;
  end

  tpt_pend_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .op_i  (op),
    .cnt_o (pend_cnt),
    .nz_o  (pend_nz)
  );

  tpt_ack_gate u_gate (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(restart_i),
    .ack_i    (ack_i),
    .pend_nz_i(pend_nz),
    .deliver_o(deliver)
  );

  tpt_fanout #(.NUM_CORES(NUM_CORES), .CORE_PRESENT(CORE_PRESENT)) u_fan (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .deliver_i(deliver),
    .irq_o    (irq_o),
    .strobe_o (core_strobe_o)
  );

  assign pending_o = pend_nz;
endmodule

// File: rtl/tick_pend_tracker_chk.sv
module tick_pend_tracker_chk #(
  parameter int                   CNT_W        = 4,
  parameter int                   NUM_CORES    = 4,
  parameter logic [NUM_CORES-1:0] CORE_PRESENT = 4'b1011
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 tick_i,
  input logic                 ack_i,
  input logic                 restart_i,
  input logic                 irq_o,
  input logic [NUM_CORES-1:0] core_strobe_o,
  input logic                 pending_o,
  input logic [CNT_W-1:0]     pend_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  a_r4_needs_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ($past(pending_o) && !$past(restart_i)));

  a_r4_one_shot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !$past(ack_i)) |=> !irq_o);

  a_r6_strobe_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_strobe_o == ({NUM_CORES{irq_o}} & CORE_PRESENT));

  a_r7_restart_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (!pending_o && !irq_o));

  a_r8_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_cnt == CNT_MAX && tick_i && !ack_i && !restart_i) |=> pend_cnt == CNT_MAX);

  a_r3_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_cnt == '0 && ack_i && !tick_i && !restart_i) |=> pend_cnt == '0);

  a_r9_tick_ack_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && ack_i && !restart_i) |=> $stable(pend_cnt));
endmodule

bind tick_pend_tracker tick_pend_tracker_chk #(
  .CNT_W(CNT_W), .NUM_CORES(NUM_CORES), .CORE_PRESENT(CORE_PRESENT)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .ack_i(ack_i),
  .restart_i(restart_i), .irq_o(irq_o), .core_strobe_o(core_strobe_o),
  .pending_o(pending_o), .pend_cnt(pend_cnt)
);

// File: tb/tick_pend_tracker_test.sv
`timescale 1ns/1ps
module tick_pend_tracker_test;
  localparam int             CNT_W = 4;
  localparam int             NC    = 4;
  localparam logic [NC-1:0]  PRES  = 4'b1011;
  localparam int             CMAX  = (1 << CNT_W) - 1;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic tick_i = 1'b0, ack_i = 1'b0, restart_i = 1'b0;
  logic irq_o, pending_o;
  logic [NC-1:0] core_strobe_o;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  // reference model state
  int  m_pend;
  bit  m_ready;
  bit  m_irq;

  always #4 clk_i = ~clk_i;

  tick_pend_tracker #(.CNT_W(CNT_W), .NUM_CORES(NC), .CORE_PRESENT(PRES)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .ack_i(ack_i),
    .restart_i(restart_i), .irq_o(irq_o), .core_strobe_o(core_strobe_o),
    .pending_o(pending_o)
  );

  function automatic int next_pend(int p, bit t, bit a, bit r);
    if (r) return 0;
    if (t && !a) return (p == CMAX) ? p : p + 1;
    if (a && !t) return (p == 0) ? 0 : p - 1;
    return p;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R2/R3 pending_o", 32'(pending_o), 32'(m_pend != 0));
    chk("R4 irq_o", 32'(irq_o), 32'(m_irq));
    chk("R6 core_strobe_o", 32'(core_strobe_o), 32'(m_irq ? PRES : '0));
  endtask

  // called at negedge: drive, advance model, wait one cycle, compare
  task automatic step(bit t, bit a, bit r);
    bit dlv;
    tick_i = t; ack_i = a; restart_i = r;
    dlv = (m_pend != 0) && m_ready && !r;
    m_irq = dlv;
    m_ready = (r || a) ? 1'b1 : (dlv ? 1'b0 : m_ready);
    m_pend = next_pend(m_pend, t, a, r);
    @(negedge clk_i);
    compare_all();
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_pend = 0; m_ready = 1'b1; m_irq = 1'b0;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 pending_o", 32'(pending_o), 0);
    chk("R1 irq_o", 32'(irq_o), 0);
    chk("R1 core_strobe_o", 32'(core_strobe_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1/R2/R4: first tick delivered, then gated
    step(1, 0, 0);
    chk("R2 pending after tick", 32'(pending_o), 1);
    step(1, 0, 0);
    chk("R1 R4 first delivery", 32'(irq_o), 1);
    step(0, 0, 0);
    chk("R4 no repeat without ack", 32'(irq_o), 0);
    step(0, 0, 0);
    chk("R4 still gated", 32'(irq_o), 0);
    // R5: ack re-arms, backlog 1 remains
    step(0, 1, 0);
    chk("R3 pending after ack", 32'(pending_o), 1);
    step(0, 0, 0);
    chk("R5 redelivery after ack", 32'(irq_o), 1);
    chk("R6 strobe mask", 32'(core_strobe_o), 32'(PRES));
    step(0, 1, 0);
    chk("R3 drained", 32'(pending_o), 0);
    step(0, 1, 0);
    step(0, 1, 0);
    chk("R3 floor at zero", 32'(pending_o), 0);
    // R9 with empty backlog
    step(1, 1, 0);
    chk("R9 empty hold", 32'(pending_o), 0);
    // R8 saturation
    for (int i = 0; i < 20; i++) step(1, 0, 0);
    for (int i = 0; i < 14; i++) step(0, 1, 0);
    chk("R8 one left after 14 acks", 32'(pending_o), 1);
    step(0, 1, 0);
    chk("R8 empty after 15 acks", 32'(pending_o), 0);
    // R9 with loaded backlog
    step(1, 0, 0);
    for (int i = 0; i < 5; i++) step(1, 1, 0);
    chk("R9 loaded hold", 32'(pending_o), 1);
    // R7 restart over loaded backlog while not ready
    for (int i = 0; i < 4; i++) step(1, 0, 0);
    step(1, 1, 1);
    chk("R7 cleared", 32'(pending_o), 0);
    chk("R7 no delivery", 32'(irq_o), 0);
    step(1, 0, 0);
    step(0, 0, 0);
    chk("R7 re-armed delivery", 32'(irq_o), 1);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      int unsigned rt = $urandom_range(99);
      int unsigned ra = $urandom_range(99);
      int unsigned rr = $urandom_range(199);
      bit hi = (i / 500) % 2;
      step(rt < (hi ? 60 : 25), ra < (hi ? 20 : 45), rr == 0);
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule